// File: doc/BRIEF.md
# Interrupt Control Register Unit

This block holds one 8-bit interrupt control and status register and derives a single interrupt request for a CPU core from it. Two hardware events latch their own flags in the register: a timer overflow pulse and an external pin interrupt pulse. A third flag is a read-only summary of an external vector of change flags. A peripheral request line, which summarises interrupts kept elsewhere, is also gated here.

Flags latch whenever their event occurs, whatever the enable bits hold. The request passes through two gates. Every source needs its own enable and the global enable. The peripheral line also needs the peripheral enable. Software reads the whole register and writes every bit except the change-summary bit through a simple port. The request output is registered.

Top module: `irq_ctrl_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight register bits and the request output. Both read 0 on the first falling edge after a reset edge.
- R2: Bit 7 is the global enable, bit 6 the peripheral enable, bit 5 the timer enable, bit 4 the external enable and bit 3 the change enable. A write sets these bits on the next rising edge and they read back unchanged.
- R3: A one-cycle timer pulse sets bit 2 at the next rising edge, whatever any enable holds.
- R4: A one-cycle external pulse sets bit 1 at the next rising edge, whatever any enable holds.
- R5: When a pulse and a software write of 0 to the same flag arrive in the same cycle, the flag ends up set.
- R6: Bit 0 reads 1 one cycle after any bit of the change vector is 1, and 0 one cycle after all of them are 0. Software writes to bit 0 have no effect.
- R7: While the global enable is 0, the request output stays 0 whatever the flags and the peripheral line hold.
- R8: The request output is registered. On each edge it takes global enable AND (timer enable AND bit 2, OR external enable AND bit 1, OR change enable AND bit 0, OR peripheral enable AND peripheral line), using the values held before that edge.
- R9: The peripheral line raises the request only when both the peripheral enable and the global enable are 1.
- R10: Software clears bit 2 or bit 1 by writing 0 to it when no pulse for that flag arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| tmr_ovf_pulse | input | 1 | Timer overflow event, one cycle |
| ext_int_pulse | input | 1 | External pin event, one cycle |
| chg_flags | input | CHG_W | External vector of change flags |
| periph_req | input | 1 | Summary of peripheral interrupts |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with CHG_W set to 3. This keeps the change vector narrow enough that every order of clearing a multi-bit vector can be driven: bit by bit, with the summary staying high until the last bit clears. The three-bit width still covers more than the single-bit case. A random phase mixes writes, pulses, vector changes and peripheral requests. This brings collisions between writes and pulses, and enable changes in the same cycle as events, within reach of the per-cycle reference model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_GIE = 7;
  localparam int BIT_PEN = 6;
  localparam int BIT_TEN = 5;
  localparam int BIT_XEN = 4;
  localparam int BIT_CEN = 3;
  localparam int BIT_TFL = 2;
  localparam int BIT_XFL = 1;
  localparam int BIT_CFL = 0;
  localparam int EN_LO   = BIT_CEN;
  localparam int EN_W    = REG_W - EN_LO;
  localparam int HW_FLAGS = 2;
  localparam int N_SRC   = 4;
  localparam int SRC_PERIPH = 3;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (wr_en)   flag_q <= wr_val;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q);
  assert_sw_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_val && !set_evt) |=> !flag_q);
endmodule

// File: rtl/irq_chg_summary.sv
module irq_chg_summary #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  output logic         any_q
);
  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |src;
  end

  assert_any_set_R6: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> any_q);
  assert_all_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |=> !any_q);
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gie,
  input  logic [N-1:0] src_en,
  input  logic [N-1:0] src_fl,
  output logic         irq_q
);
  logic [N-1:0] live;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      assign live[i] = src_en[i] & src_fl[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie & (|live);
  end

  assert_gie_off_R7: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_q);
  assert_req_on_R8: assert property (@(posedge clk) disable iff (rst)
    (gie && ((src_en & src_fl) != '0)) |=> irq_q);
  assert_req_off_R8: assert property (@(posedge clk) disable iff (rst)
    ((src_en & src_fl) == '0) |=> !irq_q);
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_ctrl_pkg::*;
#(
  parameter int CHG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             tmr_ovf_pulse,
  input  logic             ext_int_pulse,
  input  logic [CHG_W-1:0] chg_flags,
  input  logic             periph_req,
  output logic             irq
);
  logic [EN_W-1:0]     en_q;
  logic [HW_FLAGS-1:0] hw_evt;
  logic [HW_FLAGS-1:0] hw_fl;
  logic                chg_any;
  logic [N_SRC-1:0]    g_en;
  logic [N_SRC-1:0]    g_fl;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wr_data[REG_W-1:EN_LO];
  end

  // index 1 -> timer flag (bit 2), index 0 -> external flag (bit 1)
  assign hw_evt = {tmr_ovf_pulse, ext_int_pulse};

  generate
    for (genvar i = 0; i < HW_FLAGS; i++) begin : g_flag
      irq_flag_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .set_evt (hw_evt[i]),
        .wr_en   (wr_en),
        .wr_val  (wr_data[BIT_XFL + i]),
        .flag_q  (hw_fl[i])
      );
    end
  endgenerate

  irq_chg_summary #(.W(CHG_W)) u_chg (
    .clk   (clk),
    .rst   (rst),
    .src   (chg_flags),
    .any_q (chg_any)
  );

  assign rd_data = {en_q, hw_fl, chg_any};

  assign g_en = {rd_data[BIT_PEN], rd_data[BIT_TEN], rd_data[BIT_XEN], rd_data[BIT_CEN]};
  assign g_fl = {periph_req,       rd_data[BIT_TFL], rd_data[BIT_XFL], rd_data[BIT_CFL]};

  irq_req_gate #(.N(N_SRC)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .gie    (rd_data[BIT_GIE]),
    .src_en (g_en),
    .src_fl (g_fl),
    .irq_q  (irq)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq));
  assert_tmr_R3: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf_pulse |=> rd_data[BIT_TFL]);
  assert_ext_R4: assert property (@(posedge clk) disable iff (rst)
    ext_int_pulse |=> rd_data[BIT_XFL]);
  assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[REG_W-1:EN_LO] == $past(wr_data[REG_W-1:EN_LO]));
  assert_periph_R9: assert property (@(posedge clk) disable iff (rst)
    (periph_req && rd_data[BIT_PEN] && rd_data[BIT_GIE]) |=> irq);
endmodule

// File: tb/irq_ctrl_unit_tb.sv
module irq_ctrl_unit_tb;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic [7:0]    rd_data;
  logic          tmr_ovf_pulse = 1'b0;
  logic          ext_int_pulse = 1'b0;
  logic [CW-1:0] chg_flags = '0;
  logic          periph_req = 1'b0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  logic [7:0] m_reg = 8'h00;
  logic       m_irq = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_unit #(.CHG_W(CW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tmr_ovf_pulse(tmr_ovf_pulse), .ext_int_pulse(ext_int_pulse),
    .chg_flags(chg_flags), .periph_req(periph_req), .irq(irq)
  );

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    logic [7:0] nr;
    logic       ni;
    started = 1'b1;
    if (rst) begin
      nr = 8'h00;
      ni = 1'b0;
    end else begin
      ni = m_reg[7] && ((m_reg[5] && m_reg[2]) || (m_reg[4] && m_reg[1]) ||
                        (m_reg[3] && m_reg[0]) || (m_reg[6] && periph_req));
      nr = m_reg;
      if (wr_en) nr[7:1] = wr_data[7:1];
      if (tmr_ovf_pulse) nr[2] = 1'b1;
      if (ext_int_pulse) nr[1] = 1'b1;
      nr[0] = (chg_flags != 0);
    end
    m_reg = nr;
    m_irq = ni;
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk(rd_data[7:3] == m_reg[7:3], "R2", rd_data, m_reg);
      chk(rd_data[2:1] == m_reg[2:1], "R3", rd_data, m_reg);
      chk(rd_data[0] == m_reg[0], "R6", rd_data, m_reg);
      chk(irq == m_irq, "R8", {7'd0, irq}, {7'd0, m_irq});
    end
  end

  task automatic drive(input bit w, input logic [7:0] d, input bit t, input bit x);
    @(negedge clk); #1;
    wr_en = w; wr_data = d; tmr_ovf_pulse = t; ext_int_pulse = x;
    @(negedge clk); #1;
    wr_en = 1'b0; tmr_ovf_pulse = 1'b0; ext_int_pulse = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    chk(rd_data == 8'h00, "R1", rd_data, 8'h00);
    chk(irq == 1'b0, "R1", {7'd0, irq}, 8'h00);

    // R2: enable bits round-trip
    drive(1, 8'hF8, 0, 0);
    chk(rd_data == 8'hF8, "R2", rd_data, 8'hF8);
    drive(1, 8'h00, 0, 0);

    // R3 / R4: flags latch with all enables off, request stays low (R7)
    drive(0, 8'h00, 1, 0);
    chk(rd_data == 8'h04, "R3", rd_data, 8'h04);
    drive(0, 8'h00, 0, 1);
    chk(rd_data == 8'h06, "R4", rd_data, 8'h06);
    periph_req = 1'b1;
    drive(1, 8'h7E, 0, 0);
    idle(2);
    chk(irq == 1'b0, "R7", {7'd0, irq}, 8'h00);
    periph_req = 1'b0;

    // R10: software clear
    drive(1, 8'h00, 0, 0);
    chk(rd_data == 8'h00, "R10", rd_data, 8'h00);

    // R5: pulse collides with a write of 0
    drive(1, 8'h00, 1, 1);
    chk(rd_data == 8'h06, "R5", rd_data, 8'h06);
    drive(1, 8'h00, 0, 0);

    // R6: summary of change vector, writes to bit 0 ignored
    chg_flags = 3'b101;
    idle(1);
    chk(rd_data[0] == 1'b1, "R6", rd_data, 8'h01);
    drive(1, 8'h00, 0, 0);
    chk(rd_data[0] == 1'b1, "R6", rd_data, 8'h01);
    chg_flags = 3'b100;
    idle(1);
    chk(rd_data[0] == 1'b1, "R6", rd_data, 8'h01);
    chg_flags = 3'b000;
    idle(1);
    chk(rd_data == 8'h00, "R6", rd_data, 8'h00);
    drive(1, 8'h01, 0, 0);
    chk(rd_data == 8'h00, "R6", rd_data, 8'h00);

    // R8: timer source through global gate
    drive(1, 8'hA0, 1, 0);
    idle(1);
    chk(irq == 1'b1, "R8", {7'd0, irq}, 8'h01);
    drive(1, 8'h20, 0, 0);
    idle(1);
    chk(irq == 1'b0, "R7", {7'd0, irq}, 8'h00);
    drive(1, 8'h00, 0, 0);

    // R9: peripheral line needs both enables
    periph_req = 1'b1;
    drive(1, 8'h40, 0, 0);
    idle(1);
    chk(irq == 1'b0, "R9", {7'd0, irq}, 8'h00);
    drive(1, 8'h80, 0, 0);
    idle(1);
    chk(irq == 1'b0, "R9", {7'd0, irq}, 8'h00);
    drive(1, 8'hC0, 0, 0);
    idle(1);
    chk(irq == 1'b1, "R9", {7'd0, irq}, 8'h01);
    periph_req = 1'b0;
    drive(1, 8'h00, 0, 0);

    // random mix checked by the model every cycle (R8)
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); #1;
      wr_en = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      tmr_ovf_pulse = ($urandom_range(0, 5) == 0);
      ext_int_pulse = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 3) == 0) chg_flags = CW'($urandom);
      periph_req = ($urandom_range(0, 2) == 0);
    end
    wr_en = 1'b0; tmr_ovf_pulse = 1'b0; ext_int_pulse = 1'b0;

    // reset mid-run (R1)
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    chk(rd_data == 8'h00, "R1", rd_data, 8'h00);
    chk(irq == 1'b0, "R1", {7'd0, irq}, 8'h00);
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule